// File: doc/BRIEF.md
# Clock-Qualified 4:2:2 YUV Bus Formatter

This block takes luminance and colour-difference samples at half the rate of the line-locked master clock. It places them on a 16-bit parallel video bus made of two byte lanes. A clock-reference input marks every second rising edge of the master clock as a transfer edge. The outputs change only on those edges, so the bus runs at half the master rate. The luma lane carries every Y sample. The chroma lane carries one U and one V for each pair of samples, in a fixed two-slot frame: U in the first slot, V in the second. A pulse on a line-start input realigns the frame.

Input samples are in two's complement. Y passes through unchanged. U and V leave in offset-binary form. Drive is enabled either by a register bit or by an input from an external enable chain. A select input chooses which of the two is used. The enable is modelled as a flag beside data that holds its value. While the drive is off, the frame phase keeps counting, so alignment is correct when the drive comes back.

Top module: `yuv_bus_fmt`

## Requirements
- R1: During and after synchronous active-high reset, bus_oe=0, y_out=8'h00, uv_out=8'h80, cref_err=0 and out_strobe=0.
- R2: An edge is a transfer edge only when cref is 1 and cref was 0 on the previous edge. On any other edge, y_out, uv_out and out_slot hold, and out_strobe is 0 after that edge.
- R3: On an enabled transfer edge with in_valid=1, y_out takes in_y unchanged, and out_strobe is 1 after that edge.
- R4: The slots of a frame alternate: U slot (out_slot=0), then V slot (out_slot=1). The V slot outputs the V value of the U-slot sample. The U and V of the V-slot sample are discarded.
- R5: Chroma leaves in offset binary: uv_out equals the two's-complement input with bit 7 inverted (for example, input 8'h80 gives 8'h00, and input 8'h05 gives 8'h85).
- R6: The first transfer edge after reset, or after any edge with href=1, is a U slot.
- R7: When cref is 1 on two consecutive edges, the second edge is not a transfer edge, and cref_err becomes 1 and stays 1 until reset.
- R8: bus_oe follows, one edge later, reg_oe when oe_sel=0, or oe_chain when oe_sel=1.
- R9: On a transfer edge while the selected enable is 0, y_out and uv_out hold, but the slot phase still advances and a U-slot V value is still captured.
- R10: On an enabled transfer edge with in_valid=0, y_out becomes 8'h00. A U slot then outputs uv_out=8'h80, and the following V slot also outputs 8'h80.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Line-locked master clock |
| rst | input | 1 | Synchronous reset, active high |
| cref | input | 1 | Clock reference; high on transfer edges |
| href | input | 1 | Line-start pulse; realigns the frame |
| in_valid | input | 1 | The input sample is valid |
| in_y | input | 8 | Luma, two's complement |
| in_u | input | 8 | B-Y colour difference, two's complement |
| in_v | input | 8 | R-Y colour difference, two's complement |
| reg_oe | input | 1 | Output enable from the register |
| oe_sel | input | 1 | 0: use reg_oe, 1: use oe_chain |
| oe_chain | input | 1 | Output enable from the external chain |
| y_out | output | 8 | Luma lane |
| uv_out | output | 8 | Multiplexed chroma lane, offset binary |
| bus_oe | output | 1 | Drive enable for both lanes |
| out_slot | output | 1 | Slot of the last transfer: 0 = U, 1 = V |
| out_strobe | output | 1 | High after an enabled transfer edge |
| cref_err | output | 1 | Sticky flag for a repeated clock reference |

## Verification
The assertions assume that reset is held for more than one edge, so the registers hold settled values before checking starts. They also assume that cref, the enables and href change only between edges. The bench drives every input on the falling edge, holds reset for five cycles, and raises cref for one cycle in every two. The only exception is the test that deliberately holds cref high for two edges to provoke the error flag.

// File: rtl/yuvfmt_pkg.sv
package yuvfmt_pkg;
  typedef enum logic {SLOT_U = 1'b0, SLOT_V = 1'b1} uv_slot_e;

  function automatic logic [7:0] to_offset8(input logic [7:0] s);
    return {~s[7], s[6:0]};
  endfunction
endpackage

// File: rtl/cref_qual.sv
module cref_qual (
  input  logic clk,
  input  logic rst,
  input  logic cref,
  output logic qual,
  output logic err
);
  logic cref_q;

  assign qual = cref & ~cref_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cref_q <= 1'b0;
      err    <= 1'b0;
    end else begin
      cref_q <= cref;
      if (cref && cref_q) err <= 1'b1;
    end
  end
endmodule

// File: rtl/frame_phase.sv
module frame_phase
  import yuvfmt_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  logic     qual,
  input  logic     href,
  output uv_slot_e cur_slot,
  output uv_slot_e last_slot
);
  logic realign;

  always_comb begin
    if (realign) cur_slot = SLOT_U;
    else         cur_slot = (last_slot == SLOT_U) ? SLOT_V : SLOT_U;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      realign   <= 1'b1;
      last_slot <= SLOT_V;
    end else begin
      if (qual) begin
        last_slot <= cur_slot;
        realign   <= href;
      end else if (href) begin
        realign <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/lane_packer.sv
module lane_packer
  import yuvfmt_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         qual,
  input  logic         load,
  input  uv_slot_e     slot,
  input  logic         valid,
  input  logic [W-1:0] y_in,
  input  logic [W-1:0] u_in,
  input  logic [W-1:0] v_in,
  output logic [W-1:0] y_q,
  output logic [W-1:0] uv_q
);
  localparam logic [W-1:0] MID = {1'b1, {(W-1){1'b0}}};

  logic [W-1:0] v_hold;

  function automatic logic [W-1:0] flip(input logic [W-1:0] s);
    return {~s[W-1], s[W-2:0]};
  endfunction

  always_ff @(posedge clk) begin
    if (rst) begin
      v_hold <= '0;
    end else if (qual && slot == SLOT_U) begin
      v_hold <= valid ? v_in : '0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      y_q  <= '0;
      uv_q <= MID;
    end else if (load) begin
      y_q <= valid ? y_in : '0;
      if (slot == SLOT_U) uv_q <= valid ? flip(u_in) : MID;
      else                uv_q <= flip(v_hold);
    end
  end
endmodule

// File: rtl/yuv_bus_fmt.sv
module yuv_bus_fmt
  import yuvfmt_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         cref,
  input  logic         href,
  input  logic         in_valid,
  input  logic [W-1:0] in_y,
  input  logic [W-1:0] in_u,
  input  logic [W-1:0] in_v,
  input  logic         reg_oe,
  input  logic         oe_sel,
  input  logic         oe_chain,
  output logic [W-1:0] y_out,
  output logic [W-1:0] uv_out,
  output logic         bus_oe,
  output logic         out_slot,
  output logic         out_strobe,
  output logic         cref_err
);
  logic     qual;
  logic     en;
  uv_slot_e cur_slot;
  uv_slot_e last_slot;

  assign en = oe_sel ? oe_chain : reg_oe;

  cref_qual u_qual (
    .clk(clk), .rst(rst), .cref(cref), .qual(qual), .err(cref_err)
  );

  frame_phase u_phase (
    .clk(clk), .rst(rst), .qual(qual), .href(href),
    .cur_slot(cur_slot), .last_slot(last_slot)
  );

  lane_packer #(.W(W)) u_pack (
    .clk(clk), .rst(rst), .qual(qual), .load(qual & en), .slot(cur_slot),
    .valid(in_valid), .y_in(in_y), .u_in(in_u), .v_in(in_v),
    .y_q(y_out), .uv_q(uv_out)
  );

  assign out_slot = last_slot;

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_oe     <= 1'b0;
      out_strobe <= 1'b0;
    end else begin
      bus_oe     <= en;
      out_strobe <= qual & en;
    end
  end
endmodule

// File: rtl/yuv_bus_fmt_chk.sv
module yuv_bus_fmt_chk #(
  parameter int W = 8
) (
  input logic         clk,
  input logic         rst,
  input logic         cref,
  input logic         reg_oe,
  input logic         oe_sel,
  input logic         oe_chain,
  input logic [W-1:0] y_out,
  input logic [W-1:0] uv_out,
  input logic         bus_oe,
  input logic         out_slot,
  input logic         out_strobe,
  input logic         cref_err
);
  assert_reset_R1: assert property (@(posedge clk)
    $past(rst) && rst |-> !bus_oe && !cref_err && !out_strobe);

  assert_hold_R2: assert property (@(posedge clk) disable iff (rst)
    !$past(cref) |-> $stable(y_out) && $stable(uv_out) && $stable(out_slot) && !out_strobe);

  assert_err_set_R7: assert property (@(posedge clk) disable iff (rst)
    cref && $past(cref) |=> cref_err);

  assert_err_sticky_R7: assert property (@(posedge clk) disable iff (rst)
    cref_err |=> cref_err);

  assert_oe_R8: assert property (@(posedge clk) disable iff (rst)
    bus_oe == $past(oe_sel ? oe_chain : reg_oe));

  assert_disabled_hold_R9: assert property (@(posedge clk) disable iff (rst)
    !bus_oe |-> $stable(y_out) && $stable(uv_out) && !out_strobe);
endmodule

bind yuv_bus_fmt yuv_bus_fmt_chk #(.W(W)) u_chk (
  .clk(clk), .rst(rst), .cref(cref), .reg_oe(reg_oe), .oe_sel(oe_sel),
  .oe_chain(oe_chain), .y_out(y_out), .uv_out(uv_out), .bus_oe(bus_oe),
  .out_slot(out_slot), .out_strobe(out_strobe), .cref_err(cref_err)
);

// File: tb/yuv_bus_fmt_bench.sv
module yuv_bus_fmt_bench;
  logic clk = 0, rst = 1, cref = 0, href = 0, in_valid = 0;
  logic [7:0] in_y = 0, in_u = 0, in_v = 0;
  logic reg_oe = 0, oe_sel = 0, oe_chain = 0;
  logic [7:0] y_out, uv_out;
  logic bus_oe, out_slot, out_strobe, cref_err;

  int total = 0, bad = 0;
  bit finished = 0;
  bit m_realign;
  bit m_last;
  logic [7:0] m_vhold;

  always #10 clk = ~clk;

  yuv_bus_fmt u_yuv_bus_fmt (
    .clk(clk), .rst(rst), .cref(cref), .href(href), .in_valid(in_valid),
    .in_y(in_y), .in_u(in_u), .in_v(in_v), .reg_oe(reg_oe), .oe_sel(oe_sel),
    .oe_chain(oe_chain), .y_out(y_out), .uv_out(uv_out), .bus_oe(bus_oe),
    .out_slot(out_slot), .out_strobe(out_strobe), .cref_err(cref_err)
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // one transfer: cref high for one edge, low for the next
  task automatic xfer(logic v, logic [7:0] y, logic [7:0] u, logic [7:0] vv,
                      output bit slot, output logic [7:0] exp_uv);
    slot = m_realign ? 1'b0 : ~m_last;
    if (slot == 1'b0) begin
      exp_uv  = v ? {~u[7], u[6:0]} : 8'h80;
      m_vhold = v ? vv : 8'h00;
    end else begin
      exp_uv = {~m_vhold[7], m_vhold[6:0]};
    end
    m_last = slot;
    m_realign = 0;
    cref = 1; in_valid = v; in_y = y; in_u = u; in_v = vv;
    @(negedge clk);
    cref = 0;
  endtask

  task automatic t_reset;
    chk("R1 bus_oe", bus_oe, 0);
    chk("R1 y_out", y_out, 8'h00);
    chk("R1 uv_out", uv_out, 8'h80);
    chk("R1 cref_err", cref_err, 0);
    chk("R1 strobe", out_strobe, 0);
  endtask

  task automatic t_enable;
    oe_sel = 0; reg_oe = 1; @(negedge clk);
    chk("R8 reg path", bus_oe, 1);
    oe_sel = 1; oe_chain = 0; @(negedge clk);
    chk("R8 chain low", bus_oe, 0);
    oe_chain = 1; @(negedge clk);
    chk("R8 chain high", bus_oe, 1);
  endtask

  task automatic t_pair;
    bit s; logic [7:0] e;
    xfer(1, 8'h12, 8'h05, 8'hF0, s, e);
    chk("R3 y even", y_out, 8'h12);
    chk("R6 first slot U", out_slot, 0);
    chk("R5 u offset", uv_out, 8'h85);
    chk("R3 strobe", out_strobe, 1);
    @(negedge clk);
    xfer(1, 8'h34, 8'h7F, 8'h7F, s, e);
    chk("R3 y odd", y_out, 8'h34);
    chk("R4 slot V", out_slot, 1);
    chk("R4 v from even", uv_out, 8'h70);
    @(negedge clk);
    xfer(1, 8'hC3, 8'h80, 8'h00, s, e);
    chk("R5 u min", uv_out, 8'h00);
    chk("R4 slot U again", out_slot, 0);
    @(negedge clk);
  endtask

  task automatic t_no_cref;
    logic [7:0] y0 = y_out, uv0 = uv_out;
    in_valid = 1; in_y = 8'h55; in_u = 8'h66; cref = 0;
    @(negedge clk); @(negedge clk);
    chk("R2 y hold", y_out, y0);
    chk("R2 uv hold", uv_out, uv0);
    chk("R2 no strobe", out_strobe, 0);
  endtask

  task automatic t_href;
    bit s; logic [7:0] e;
    href = 1; @(negedge clk); href = 0;
    m_realign = 1;
    xfer(1, 8'h21, 8'h11, 8'h22, s, e);
    chk("R6 realign U", out_slot, 0);
    chk("R6 uv", uv_out, e);
    @(negedge clk);
    xfer(1, 8'h22, 8'h33, 8'h44, s, e);
    chk("R6 then V", out_slot, 1);
    chk("R4 v 22", uv_out, 8'hA2);
    @(negedge clk);
  endtask

  task automatic t_double;
    bit s; logic [7:0] e;
    xfer(1, 8'hAA, 8'h01, 8'h02, s, e);
    cref = 1; in_y = 8'hBB;
    @(negedge clk);
    chk("R7 second ignored y", y_out, 8'hAA);
    chk("R7 no strobe", out_strobe, 0);
    chk("R7 err set", cref_err, 1);
    cref = 0; @(negedge clk); @(negedge clk);
    chk("R7 err sticky", cref_err, 1);
    xfer(1, 8'hCC, 8'h00, 8'h00, s, e);
    chk("R7 phase", out_slot, s);
    chk("R7 uv", uv_out, e);
    @(negedge clk);
  endtask

  task automatic t_disabled;
    bit s; logic [7:0] e;
    logic [7:0] y0;
    href = 1; @(negedge clk); href = 0; m_realign = 1;
    oe_sel = 0; reg_oe = 0;
    y0 = y_out;
    xfer(1, 8'h99, 8'h10, 8'h3C, s, e);
    chk("R9 y held", y_out, y0);
    chk("R9 oe off", bus_oe, 0);
    @(negedge clk);
    reg_oe = 1;
    xfer(1, 8'h98, 8'h00, 8'h00, s, e);
    chk("R9 phase advanced", out_slot, 1);
    chk("R9 v captured", uv_out, 8'hBC);
    chk("R9 y", y_out, 8'h98);
    @(negedge clk);
  endtask

  task automatic t_invalid;
    bit s; logic [7:0] e;
    xfer(0, 8'h77, 8'h77, 8'h77, s, e);
    chk("R10 y blank", y_out, 8'h00);
    chk("R10 slot U", out_slot, 0);
    chk("R10 uv blank", uv_out, 8'h80);
    @(negedge clk);
    xfer(1, 8'h40, 8'h12, 8'h34, s, e);
    chk("R10 v blank", uv_out, 8'h80);
    @(negedge clk);
  endtask

  initial begin
    m_realign = 1; m_last = 1; m_vhold = 0;
    repeat (5) @(negedge clk);
    t_reset();
    rst = 0;
    @(negedge clk);
    t_reset();
    t_enable();
    t_pair();
    t_no_cref();
    t_href();
    t_double();
    t_disabled();
    t_invalid();
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog actual=running expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule